// File: doc/BRIEF.md
# Pulse-Swallow Divider Pair for a PLL Synthesizer

This block holds the digital counters of a PLL frequency synthesizer. The feedback side counts output strobes from an external dual-modulus 16/17 prescaler. A 4-bit swallow counter and a 10-bit main counter set the modulus-control line, so that one feedback period spans `16*P + A` VCO cycles. The reference side counts reference-clock strobes and emits one pulse every `R` strobes. Both sides therefore arrive at the same comparison rate. Both outputs are single-cycle pulses meant for a phase-frequency detector.

The block holds two complete settings banks. Each bank has a feedback ratio, a reference ratio and a 2-bit charge-pump current code. A register select bit chooses the bank. An external override pin takes precedence over that bit whenever the pin is driven. Each divider loads its ratio from the active bank only at its own terminal count, so a bank change or a rewrite never cuts a period short. A write that breaks the ratio limits is refused, and the refusal is flagged.

Top module: `swallow_div_pair`

## Requirements
- R1: Reset state:
  - `fb_pulse_o`, `ref_pulse_o`, `err_o` and `mod17_o` are low.
  - `cp_o` is 0.
  - Both banks hold feedback ratio 256, reference ratio 2 and charge-pump code 0.
- R2: A feedback ratio word `M` (14 bits) splits into `P = M[13:4]` and `A = M[3:0]`. With the prescaler dividing by 17 while `mod17_o` is high and by 16 otherwise, `fb_pulse_o` repeats every `M` VCO cycles.
- R3: Within each feedback period, `mod17_o` is high for exactly the first `A` prescaler strobes. It is low for the rest of the period, and it never rises except in the cycle that `fb_pulse_o` is high.
- R4: `ref_pulse_o` repeats every `R` strobes of `ref_tick_i`, where `R` is the 11-bit reference ratio of the active bank.
- R5: The active bank is selected as follows:
  - When `sel_ovr_en_i` is high, `sel_ovr_val_i` selects the bank.
  - Otherwise `sel_reg_i` selects the bank.
  - Value 1 selects bank one (written with `wr_bank_i=1`); value 0 selects bank two.
- R6: A new ratio, from a bank switch or a write, applies only from the next terminal count. The period in progress completes with the old ratio.
- R7: `cp_o` takes the charge-pump code of the active bank. It changes only in the cycle that `fb_pulse_o` is high.
- R8: A write is refused when `M < 256`, `P < A` or `R < 2`. A refused write leaves both banks unchanged and drives `err_o` high in the cycle after the write. An accepted write drives `err_o` low in the cycle after the write.
- R9: `fb_pulse_o` and `ref_pulse_o` are each high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, one cycle per VCO cycle in the bench model |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pre_tick_i | input | 1 | One-cycle strobe at each prescaler output cycle |
| ref_tick_i | input | 1 | One-cycle strobe at each reference clock cycle |
| wr_en_i | input | 1 | Write strobe for one bank |
| wr_bank_i | input | 1 | Bank written: 1 = bank one, 0 = bank two |
| wr_m_i | input | 14 | Feedback ratio {P, A} |
| wr_r_i | input | 11 | Reference ratio |
| wr_cp_i | input | 2 | Charge-pump current code |
| sel_reg_i | input | 1 | Register bank select bit |
| sel_ovr_en_i | input | 1 | High while the override pin is driven |
| sel_ovr_val_i | input | 1 | Level on the override pin |
| fb_pulse_o | output | 1 | Feedback terminal-count pulse |
| mod17_o | output | 1 | Prescaler modulus control, high = divide by 17 |
| ref_pulse_o | output | 1 | Reference terminal-count pulse |
| cp_o | output | 2 | Active charge-pump code |
| err_o | output | 1 | Last write was refused |

## Verification
The assertions assume the following about the inputs:
- `pre_tick_i` behaves like a real prescaler that honours `mod17_o`.
- Only ratios that pass the write check ever reach the counters, so the swallow count always drains before the main count ends.

The bench meets these assumptions in three ways:
- It models the 16/17 prescaler itself, reloading it from `mod17_o` after every strobe.
- It draws random feedback ratios only from 256 to 2000 and reference ratios only from 2 to 300.
- It sends out-of-range values only through directed writes that the block must refuse.

The reference strobe is random, with roughly three of every four cycles active.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int A_W       = 4;
  localparam int P_W       = 10;
  localparam int M_W       = P_W + A_W;
  localparam int R_W       = 11;
  localparam int CP_W      = 2;
  localparam int NUM_BANKS = 2;

  typedef struct packed {
    logic [M_W-1:0]  m;
    logic [R_W-1:0]  r;
    logic [CP_W-1:0] cp;
  } bank_t;
endpackage

// File: rtl/sdiv_bank_regs.sv
module sdiv_bank_regs
  import sdiv_pkg::*;
#(
  parameter int unsigned M_MIN  = 256,
  parameter int unsigned R_MIN  = 2,
  parameter int unsigned RST_M  = 256,
  parameter int unsigned RST_R  = 2,
  parameter int unsigned RST_CP = 0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  wr_bank_i,
  input  bank_t wr_data_i,
  input  logic  sel_reg_i,
  input  logic  sel_ovr_en_i,
  input  logic  sel_ovr_val_i,
  output bank_t active_o,
  output logic  err_o
);
  bank_t          bank_vec [NUM_BANKS];
  logic [P_W-1:0] p_fld;
  logic [A_W-1:0] a_fld;
  logic           wr_valid;
  logic           sel_eff;
  logic           err_q;

  assign p_fld = wr_data_i.m[M_W-1:A_W];
  assign a_fld = wr_data_i.m[A_W-1:0];

  always_comb begin
    wr_valid = (32'(wr_data_i.m) >= M_MIN)
            && (P_W'(a_fld) <= p_fld)
            && (32'(wr_data_i.r) >= R_MIN);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q.m  <= M_W'(RST_M);
        q.r  <= R_W'(RST_R);
        q.cp <= CP_W'(RST_CP);
      end else if (wr_en_i && wr_valid && (int'(wr_bank_i) == b)) begin
        q <= wr_data_i;
      end
    end
    assign bank_vec[b] = q;
  end

  // A driven override pin wins over the register bit
  assign sel_eff  = sel_ovr_en_i ? sel_ovr_val_i : sel_reg_i;
  assign active_o = bank_vec[sel_eff];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (wr_en_i) err_q <= !wr_valid;
  end
  assign err_o = err_q;

  // R8
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(wr_en_i));
endmodule

// File: rtl/sdiv_fb_div.sv
module sdiv_fb_div
  import sdiv_pkg::*;
#(
  parameter int unsigned RST_M  = 256,
  parameter int unsigned RST_CP = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pre_tick_i,
  input  logic [M_W-1:0]  ratio_i,
  input  logic [CP_W-1:0] cp_i,
  output logic            fb_pulse_o,
  output logic            mod17_o,
  output logic [CP_W-1:0] cp_o
);
  localparam int unsigned RST_P = RST_M / (2 ** A_W);
  localparam int unsigned RST_A = RST_M % (2 ** A_W);

  logic [P_W-1:0]  p_cnt;
  logic [A_W-1:0]  a_cnt;
  logic [CP_W-1:0] cp_q;
  logic            pulse_q;
  logic            tc;

  assign tc = pre_tick_i && (p_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_cnt   <= P_W'(RST_P - 1);
      a_cnt   <= A_W'(RST_A);
      cp_q    <= CP_W'(RST_CP);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tc;
      if (tc) begin
        // reload only here: bank changes never split a period
        p_cnt <= ratio_i[M_W-1:A_W] - P_W'(1);
        a_cnt <= ratio_i[A_W-1:0];
        cp_q  <= cp_i;
      end else if (pre_tick_i) begin
        p_cnt <= p_cnt - P_W'(1);
        if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
      end
    end
  end

  assign fb_pulse_o = pulse_q;
  assign mod17_o    = (a_cnt != '0);
  assign cp_o       = cp_q;

  // R3
  swallow_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |-> (a_cnt == '0));
  // R3
  mod_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod17_o) |-> fb_pulse_o);
  // R7
  cp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_pulse_o |-> $stable(cp_o));
  // R9
  fb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o);
endmodule

// File: rtl/sdiv_ref_div.sv
module sdiv_ref_div
  import sdiv_pkg::*;
#(
  parameter int unsigned RST_R = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_tick_i,
  input  logic [R_W-1:0] ratio_i,
  output logic           ref_pulse_o
);
  logic [R_W-1:0] r_cnt;
  logic           pulse_q;
  logic           tc;

  assign tc = ref_tick_i && (r_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_cnt   <= R_W'(RST_R - 1);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tc;
      if (tc)              r_cnt <= ratio_i - R_W'(1);
      else if (ref_tick_i) r_cnt <= r_cnt - R_W'(1);
    end
  end

  assign ref_pulse_o = pulse_q;

  // R9
  ref_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);
  // R4
  ref_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> $past(ref_tick_i));
endmodule

// File: rtl/swallow_div_pair.sv
module swallow_div_pair
  import sdiv_pkg::*;
#(
  parameter int unsigned M_MIN  = 256,
  parameter int unsigned R_MIN  = 2,
  parameter int unsigned RST_M  = 256,
  parameter int unsigned RST_R  = 2,
  parameter int unsigned RST_CP = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pre_tick_i,
  input  logic            ref_tick_i,
  input  logic            wr_en_i,
  input  logic            wr_bank_i,
  input  logic [M_W-1:0]  wr_m_i,
  input  logic [R_W-1:0]  wr_r_i,
  input  logic [CP_W-1:0] wr_cp_i,
  input  logic            sel_reg_i,
  input  logic            sel_ovr_en_i,
  input  logic            sel_ovr_val_i,
  output logic            fb_pulse_o,
  output logic            mod17_o,
  output logic            ref_pulse_o,
  output logic [CP_W-1:0] cp_o,
  output logic            err_o
);
  bank_t wr_data;
  bank_t active;

  assign wr_data.m  = wr_m_i;
  assign wr_data.r  = wr_r_i;
  assign wr_data.cp = wr_cp_i;

  sdiv_bank_regs #(
    .M_MIN (M_MIN), .R_MIN (R_MIN),
    .RST_M (RST_M), .RST_R (RST_R), .RST_CP (RST_CP)
  ) u_banks (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_bank_i     (wr_bank_i),
    .wr_data_i     (wr_data),
    .sel_reg_i     (sel_reg_i),
    .sel_ovr_en_i  (sel_ovr_en_i),
    .sel_ovr_val_i (sel_ovr_val_i),
    .active_o      (active),
    .err_o         (err_o)
  );

  sdiv_fb_div #(.RST_M (RST_M), .RST_CP (RST_CP)) u_fb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pre_tick_i (pre_tick_i),
    .ratio_i    (active.m),
    .cp_i       (active.cp),
    .fb_pulse_o (fb_pulse_o),
    .mod17_o    (mod17_o),
    .cp_o       (cp_o)
  );

  sdiv_ref_div #(.RST_R (RST_R)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_tick_i  (ref_tick_i),
    .ratio_i     (active.r),
    .ref_pulse_o (ref_pulse_o)
  );
endmodule

// File: tb/swallow_div_pair_tb_top.sv
`timescale 1ns/1ps
module swallow_div_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_tick = 1'b0, ref_tick = 1'b0;
  logic        wr_en = 1'b0, wr_bank = 1'b0;
  logic [13:0] wr_m = '0;
  logic [10:0] wr_r = '0;
  logic [1:0]  wr_cp = '0;
  logic        sel_reg = 1'b1, ovr_en = 1'b0, ovr_val = 1'b0;
  logic        fb_pulse_o, mod17_o, ref_pulse_o, err_o;
  logic [1:0]  cp_o;

  int checks = 0, fails = 0;
  int cyc = 0, fb_last = 0, fb_cnt = 0, fb_per = 0, fb_a = 0, fb_cp = 0;
  int ref_cnt = 0, ref_per = 0, m17_acc = 0, ref_acc = 0, pc = 15;
  bit fb_prev = 0, ref_prev = 0;

  swallow_div_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pre_tick_i(pre_tick), .ref_tick_i(ref_tick),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_m_i(wr_m), .wr_r_i(wr_r),
    .wr_cp_i(wr_cp), .sel_reg_i(sel_reg), .sel_ovr_en_i(ovr_en),
    .sel_ovr_val_i(ovr_val), .fb_pulse_o(fb_pulse_o), .mod17_o(mod17_o),
    .ref_pulse_o(ref_pulse_o), .cp_o(cp_o), .err_o(err_o)
  );

  initial forever #2.5 clk = ~clk;

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // prescaler model and pulse monitor, one process to keep ordering fixed
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      pc = 15; pre_tick = 0; ref_tick = 0; m17_acc = 0; ref_acc = 0;
      fb_prev = 0; ref_prev = 0;
    end else begin
      cyc++;
      if (fb_pulse_o) begin
        chk_eq("R9 fb pulse width", int'(fb_prev), 0);
        fb_per = cyc - fb_last; fb_last = cyc;
        fb_a = m17_acc; m17_acc = 0; fb_cp = int'(cp_o); fb_cnt++;
      end
      fb_prev = fb_pulse_o;
      if (ref_pulse_o) begin
        chk_eq("R9 ref pulse width", int'(ref_prev), 0);
        ref_per = ref_acc; ref_acc = 0; ref_cnt++;
      end
      ref_prev = ref_pulse_o;
      if (pre_tick) begin
        pc = mod17_o ? 16 : 15;
        if (mod17_o) m17_acc++;
      end else begin
        pc--;
      end
      pre_tick = (pc == 0);
      ref_tick = ($urandom % 4) != 0;
      if (ref_tick) ref_acc++;
    end
  end

  task automatic wait_pulses(int n);
    int f0 = fb_cnt, r0 = ref_cnt;
    while (fb_cnt < f0 + n || ref_cnt < r0 + n) @(negedge clk);
  endtask

  task automatic wait_fb(int n);
    int f0 = fb_cnt;
    while (fb_cnt < f0 + n) @(negedge clk);
  endtask

  task automatic write_bank(bit b, int m, int r, int cp, int exp_err, string req);
    @(negedge clk);
    wr_bank = b; wr_m = 14'(m); wr_r = 11'(r); wr_cp = 2'(cp); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    #1 chk_eq(req, int'(err_o), exp_err);
  endtask

  task automatic run_ratio(int m, int r, int cp);
    write_bank(1, m, r, cp, 0, "R8 accepted write");
    wait_pulses(2);
    chk_eq("R2 feedback period", fb_per, m);
    chk_eq("R3 divide-by-17 count", fb_a, m % 16);
    chk_eq("R7 charge-pump code", fb_cp, cp);
    chk_eq("R4 reference period", ref_per, r);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2417));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_eq("R1 fb pulse", int'(fb_pulse_o), 0);
    chk_eq("R1 ref pulse", int'(ref_pulse_o), 0);
    chk_eq("R1 err", int'(err_o), 0);
    chk_eq("R1 mod17", int'(mod17_o), 0);
    chk_eq("R1 cp", int'(cp_o), 0);
    rst_n = 1;
    wait_pulses(2);
    chk_eq("R1 default feedback ratio", fb_per, 256);
    chk_eq("R1 default reference ratio", ref_per, 2);
    chk_eq("R1 default swallow", fb_a, 0);

    for (int i = 0; i < 6; i++)
      run_ratio(256 + int'($urandom % 1745), 2 + int'($urandom % 299), int'($urandom % 4));
    run_ratio(271, 2, 3);        // A = 15 with P = 16
    run_ratio(16383, 2047, 1);   // top of both ranges

    // R5 R6 bank switch mid-run
    write_bank(1, 500, 40, 2, 0, "R8 accepted write");
    write_bank(0, 777, 13, 1, 0, "R8 accepted write");
    wait_pulses(2);
    chk_eq("R5 inactive bank ignored", fb_per, 500);
    wait_fb(1);
    sel_reg = 0;
    wait_fb(1);
    chk_eq("R6 period in progress keeps old ratio", fb_per, 500);
    chk_eq("R7 cp switches at terminal count", fb_cp, 1);
    wait_pulses(2);
    chk_eq("R5 bank two feedback", fb_per, 777);
    chk_eq("R3 bank two swallow", fb_a, 9);
    chk_eq("R5 bank two reference", ref_per, 13);

    ovr_en = 1; ovr_val = 1;
    wait_pulses(2);
    chk_eq("R5 override high feedback", fb_per, 500);
    chk_eq("R5 override high reference", ref_per, 40);
    ovr_val = 0; sel_reg = 1;
    wait_pulses(2);
    chk_eq("R5 override low beats register", fb_per, 777);
    ovr_en = 0;
    wait_pulses(2);
    chk_eq("R5 register select restored", fb_per, 500);
    chk_eq("R7 bank one cp", fb_cp, 2);

    // R8 refused writes
    write_bank(1, 255, 40, 0, 1, "R8 M below limit");
    write_bank(1, 600, 1, 0, 1, "R8 R below limit");
    write_bank(1, 0, 0, 3, 1, "R8 zero ratios");
    write_bank(0, 100, 5, 3, 1, "R8 refused on bank two");
    wait_pulses(2);
    chk_eq("R8 bank one kept feedback", fb_per, 500);
    chk_eq("R8 bank one kept reference", ref_per, 40);
    chk_eq("R8 bank one kept cp", fb_cp, 2);
    sel_reg = 0;
    wait_pulses(3);
    chk_eq("R8 bank two kept feedback", fb_per, 777);
    chk_eq("R8 bank two kept reference", ref_per, 13);
    sel_reg = 1;
    write_bank(1, 256, 2, 0, 0, "R8 error cleared by accepted write");
    wait_pulses(3);
    chk_eq("R2 minimum ratio", fb_per, 256);
    finish_run();
  end
endmodule